// File: doc/BRIEF.md
# Shared-Memory Mailbox Doorbell and Interrupt Registers

This block is the register slave of a mailbox device through which several nodes share one memory region. It holds four 32-bit words: an interrupt enable mask, an interrupt cause word, a read-only node position and a write-only doorbell. A level interrupt is raised while any cause bit is set and also enabled. Software learns about events by reading the cause word. That read hands back the pending bits and clears them in the same access.

To ring another node, software writes the doorbell word with a target node number and a vector number. The block checks that request against a peer table driven from outside. The table gives the highest peer number in use and, for each peer, how many vectors it has registered. A request that passes both checks leaves the block as a one-cycle notify strobe that carries the target and the vector. A request that fails either check is discarded. A separate event input can load an 8-bit value into the cause word, so that incoming notifications raise the local interrupt.

Top module: `mbx_doorbell_top`

## Requirements
- R1: While reset is asserted, and after it is released, the cause word and the mask read as zero, irq_o is low, and notify_o and rd_valid_o are low.
- R2: irq_o is high exactly when the bitwise AND of the cause word and the mask is non-zero. It follows every update of either word in the cycle after the update.
- R3: A write to word 0 (byte offset 0x0) replaces all 32 bits of the mask. A read of word 0 returns the mask.
- R4: A write to word 1 (byte offset 0x4) replaces all 32 bits of the cause word. An event pulse loads the cause word with its 8-bit value, zero-extended. When a bus write to word 1 and an event fall in the same cycle, the bus write sets the result.
- R5: A read of word 1 returns the cause value held before the read, and the cause word becomes zero after it. An event in the same cycle as the read loads its value instead of the zero.
- R6: A read of word 2 (byte offset 0x8) returns {16'h0000, local_id_i} when shm_mapped_i is high, and 32'hFFFF_FFFF when it is low.
- R7: A write to word 3 (byte offset 0xC) is a doorbell. Bits 31:16 give the target node and bits 7:0 give the vector. An accepted doorbell raises notify_o for exactly one cycle, in the cycle after the write, with notify_dest_o and notify_vec_o set to those fields.
- R8: A doorbell whose target is greater than peer_max_i produces no notify strobe.
- R9: A doorbell whose vector is greater than or equal to the target's vector count (peer_cnt_i bits [t*CNT_W +: CNT_W] for target t) produces no notify strobe.
- R10: The decode uses only address bits 7:2. Bits 1:0 and the bits above 7 are ignored. Reads of word 3 and of words 4 to 63 return zero. Writes to words 2 and 4 to 63 change no register.
- R11: Each read raises rd_valid_o for one cycle, in the cycle after the request, with rd_data_o holding the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write request (never together with bus_rd_i) |
| bus_rd_i | input | 1 | Read request |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |
| evt_valid_i | input | 1 | Incoming event strobe |
| evt_data_i | input | 8 | Event value for the cause word |
| local_id_i | input | 16 | Local node position |
| shm_mapped_i | input | 1 | Shared memory is mapped |
| peer_max_i | input | IDX_W | Highest registered peer number |
| peer_cnt_i | input | NUM_PEERS*CNT_W | Registered vector count per peer, packed |
| irq_o | output | 1 | Level interrupt |
| notify_o | output | 1 | Doorbell notify strobe |
| notify_dest_o | output | 16 | Target node of the strobe |
| notify_vec_o | output | 8 | Vector of the strobe |

## Verification
The bench aims at the doorbell limits. It uses a target equal to peer_max_i, which must pass, and one just above it, which must drop. It uses a vector equal to the target's count minus one, which must pass, and one equal to the count, which must drop; a peer with a count of zero must drop everything. An off-by-one in either compare would send strobes to dead peers or lose valid ones. It also collides an event with a cause-word write and with a cause-word read. A wrong priority would show up as a lost software write, or as a lost event after the clear-on-read. Aliased addresses, with junk in bits 1:0 and above bit 7, catch a decode that uses too many bits. Random traffic then cross-checks irq_o against a model after every step.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DATA_W  = 32;
  localparam int NODE_W  = 16;
  localparam int VEC_W   = 8;
  localparam int WORD_W  = 6;

  typedef enum logic [WORD_W-1:0] {
    WRD_MASK  = 6'd0,
    WRD_CAUSE = 6'd1,
    WRD_POS   = 6'd2,
    WRD_BELL  = 6'd3
  } mbx_word_e;
endpackage

// File: rtl/mbx_irq_regs.sv
module mbx_irq_regs
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mask_i,
  input  logic              wr_cause_i,
  input  logic              rd_cause_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              evt_valid_i,
  input  logic [VEC_W-1:0]  evt_data_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] cause_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] mask_q, mask_d;
  logic [DATA_W-1:0] cause_q, cause_d;
  logic              mask_en, cause_en;

  always_comb begin
    mask_en  = wr_mask_i;
    mask_d   = wdata_i;
    cause_en = wr_cause_i | evt_valid_i | rd_cause_i;
    if (wr_cause_i)       cause_d = wdata_i;
    else if (evt_valid_i) cause_d = {{(DATA_W-VEC_W){1'b0}}, evt_data_i};
    else                  cause_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      cause_q <= '0;
    end else begin
      if (mask_en)  mask_q  <= mask_d;
      if (cause_en) cause_q <= cause_d;
    end
  end

  assign mask_o  = mask_q;
  assign cause_o = cause_q;
  assign irq_o   = |(cause_q & mask_q);

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask_i |=> mask_q == $past(wdata_i)); // R3
  AST_CAUSE_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cause_i |=> cause_q == $past(wdata_i)); // R4
  AST_EVT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid_i && !wr_cause_i) |=> cause_q[VEC_W-1:0] == $past(evt_data_i) && cause_q[DATA_W-1:VEC_W] == '0); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cause_i && !wr_cause_i && !evt_valid_i) |=> cause_q == '0); // R5
endmodule

// File: rtl/mbx_bell_check.sv
module mbx_bell_check
  import mbx_pkg::*;
#(
  parameter int NUM_PEERS = 8,
  parameter int CNT_W     = 8,
  localparam int IDX_W    = $clog2(NUM_PEERS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bell_wr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [IDX_W-1:0]           peer_max_i,
  input  logic [NUM_PEERS*CNT_W-1:0] peer_cnt_i,
  output logic                       notify_o,
  output logic [NODE_W-1:0]          notify_dest_o,
  output logic [VEC_W-1:0]           notify_vec_o
);
  logic [CNT_W-1:0]  cnt_tab [NUM_PEERS];
  logic [NODE_W-1:0] dest;
  logic [VEC_W-1:0]  vec;
  logic [CNT_W-1:0]  dest_cnt;
  logic              dest_ok, vec_ok, accept;
  logic              notify_q;
  logic [NODE_W-1:0] dest_q;
  logic [VEC_W-1:0]  vec_q;
  logic [7:0]        unused_mid;

  for (genvar p = 0; p < NUM_PEERS; p++) begin : g_unpack
    assign cnt_tab[p] = peer_cnt_i[p*CNT_W +: CNT_W];
  end

  always_comb begin
    dest     = wdata_i[31:16];
    vec      = wdata_i[7:0];
    dest_ok  = 32'(dest) <= 32'(peer_max_i);
    dest_cnt = cnt_tab[dest[IDX_W-1:0]];
    vec_ok   = 32'(vec) < 32'(dest_cnt);
    accept   = bell_wr_i & dest_ok & vec_ok;
  end

  assign unused_mid = wdata_i[15:8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      notify_q <= 1'b0;
      dest_q   <= '0;
      vec_q    <= '0;
    end else begin
      notify_q <= accept;
      if (accept) begin
        dest_q <= dest;
        vec_q  <= vec;
      end
    end
  end

  assign notify_o      = notify_q;
  assign notify_dest_o = dest_q;
  assign notify_vec_o  = vec_q;

  AST_NOTIFY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    notify_o |-> $past(bell_wr_i)); // R7
  AST_NOTIFY_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    notify_o |-> (notify_dest_o == $past(wdata_i[31:16]) && notify_vec_o == $past(wdata_i[7:0]))); // R7
  AST_DEST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bell_wr_i && 32'(wdata_i[31:16]) > 32'(peer_max_i)) |=> !notify_o); // R8
  AST_NOTIFY_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    notify_o |-> 32'(notify_dest_o) <= 32'($past(peer_max_i))); // R8
endmodule

// File: rtl/mbx_rd_mux.sv
module mbx_rd_mux
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] cause_i,
  input  logic [NODE_W-1:0] local_id_i,
  input  logic              mapped_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] data_d, data_q;
  logic              valid_q;

  always_comb begin
    case (word_i)
      WRD_MASK:  data_d = mask_i;
      WRD_CAUSE: data_d = cause_i;
      WRD_POS:   data_d = mapped_i ? {{(DATA_W-NODE_W){1'b0}}, local_id_i} : '1;
      default:   data_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= rd_i;
      if (rd_i) data_q <= data_d;
    end
  end

  assign rd_valid_o = valid_q;
  assign rd_data_o  = data_q;

  AST_POS_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && word_i == WRD_POS && !mapped_i) |=> rd_data_o == '1); // R6
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> rd_valid_o); // R11
  AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> !rd_valid_o); // R11
endmodule

// File: rtl/mbx_doorbell_top.sv
module mbx_doorbell_top
  import mbx_pkg::*;
#(
  parameter int NUM_PEERS = 8,
  parameter int CNT_W     = 8,
  parameter int ADDR_W    = 12,
  localparam int IDX_W    = $clog2(NUM_PEERS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr_i,
  input  logic                       bus_rd_i,
  input  logic [ADDR_W-1:0]          bus_addr_i,
  input  logic [31:0]                bus_wdata_i,
  output logic                       rd_valid_o,
  output logic [31:0]                rd_data_o,
  input  logic                       evt_valid_i,
  input  logic [7:0]                 evt_data_i,
  input  logic [15:0]                local_id_i,
  input  logic                       shm_mapped_i,
  input  logic [IDX_W-1:0]           peer_max_i,
  input  logic [NUM_PEERS*CNT_W-1:0] peer_cnt_i,
  output logic                       irq_o,
  output logic                       notify_o,
  output logic [15:0]                notify_dest_o,
  output logic [7:0]                 notify_vec_o
);
  logic              rst_meta, rst_sync;
  logic [WORD_W-1:0] word;
  logic              wr_mask, wr_cause, rd_cause, wr_bell;
  logic [DATA_W-1:0] mask_q, cause_q;
  logic              unused_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign word        = bus_addr_i[7:2];
  assign unused_addr = ^{bus_addr_i[1:0], bus_addr_i[ADDR_W-1:8]};

  always_comb begin
    wr_mask  = bus_wr_i && (word == WRD_MASK);
    wr_cause = bus_wr_i && (word == WRD_CAUSE);
    wr_bell  = bus_wr_i && (word == WRD_BELL);
    rd_cause = bus_rd_i && (word == WRD_CAUSE);
  end

  mbx_irq_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_sync),
    .wr_mask_i   (wr_mask),
    .wr_cause_i  (wr_cause),
    .rd_cause_i  (rd_cause),
    .wdata_i     (bus_wdata_i),
    .evt_valid_i (evt_valid_i),
    .evt_data_i  (evt_data_i),
    .mask_o      (mask_q),
    .cause_o     (cause_q),
    .irq_o       (irq_o)
  );

  mbx_bell_check #(.NUM_PEERS(NUM_PEERS), .CNT_W(CNT_W)) u_bell (
    .clk           (clk),
    .rst_n         (rst_sync),
    .bell_wr_i     (wr_bell),
    .wdata_i       (bus_wdata_i),
    .peer_max_i    (peer_max_i),
    .peer_cnt_i    (peer_cnt_i),
    .notify_o      (notify_o),
    .notify_dest_o (notify_dest_o),
    .notify_vec_o  (notify_vec_o)
  );

  mbx_rd_mux u_rd (
    .clk        (clk),
    .rst_n      (rst_sync),
    .rd_i       (bus_rd_i),
    .word_i     (word),
    .mask_i     (mask_q),
    .cause_i    (cause_q),
    .local_id_i (local_id_i),
    .mapped_i   (shm_mapped_i),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync |-> (!irq_o && !notify_o && !rd_valid_o)); // R1
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_sync)
    (irq_o && $past(rst_sync) && $stable(mask_q)) |-> mask_q != '0); // R2
endmodule

// File: tb/sim_mbx_doorbell_top.sv
`timescale 1ns/1ps
module sim_mbx_doorbell_top;
  localparam int NP = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_wr, bus_rd;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic rd_valid;
  logic [31:0] rd_data;
  logic evt_valid;
  logic [7:0] evt_data;
  logic [15:0] local_id;
  logic shm_mapped;
  logic [2:0] peer_max;
  logic [NP*CW-1:0] peer_cnt;
  logic irq, notify;
  logic [15:0] ndest;
  logic [7:0] nvec;

  int checks = 0;
  int fails  = 0;
  logic [31:0] m_mask, m_cause;

  always #2 clk = ~clk;

  mbx_doorbell_top #(.NUM_PEERS(NP), .CNT_W(CW), .ADDR_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .rd_valid_o(rd_valid),
    .rd_data_o(rd_data), .evt_valid_i(evt_valid), .evt_data_i(evt_data),
    .local_id_i(local_id), .shm_mapped_i(shm_mapped), .peer_max_i(peer_max),
    .peer_cnt_i(peer_cnt), .irq_o(irq), .notify_o(notify),
    .notify_dest_o(ndest), .notify_vec_o(nvec)
  );

  function automatic int cnt_of(input int d);
    return d;  // peer d has d vectors
  endfunction

  function automatic logic bell_ok(input logic [31:0] wd);
    int d = int'(wd[31:16]);
    int v = int'(wd[7:0]);
    if (d > int'(peer_max)) return 1'b0;
    return v < cnt_of(d);
  endfunction

  function automatic logic [31:0] model_rd(input logic [5:0] w);
    case (w)
      6'd0: return m_mask;
      6'd1: return m_cause;
      6'd2: return shm_mapped ? {16'h0, local_id} : 32'hFFFF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input logic wr, input logic rd, input logic [11:0] addr,
                    input logic [31:0] wd, input logic ev, input logic [7:0] evd,
                    input string tag);
    logic [5:0] w = addr[7:2];
    logic [31:0] exp_rd = model_rd(w);
    logic exp_n = wr && (w == 6'd3) && bell_ok(wd);
    string ntag;
    ntag = tag;
    if (wr && w == 6'd3) begin
      if (int'(wd[31:16]) > int'(peer_max)) ntag = {tag, "/R8"};
      else if (!bell_ok(wd)) ntag = {tag, "/R9"};
      else ntag = {tag, "/R7"};
    end
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_wdata = wd;
    evt_valid = ev; evt_data = evd;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; evt_valid = 1'b0;
    if (wr && w == 6'd0) m_mask = wd;
    if (wr && w == 6'd1) m_cause = wd;
    else if (ev) m_cause = {24'h0, evd};
    else if (rd && w == 6'd1) m_cause = 32'h0;
    chk({tag, " irq R2"}, {31'h0, irq}, {31'h0, |(m_cause & m_mask)});
    chk({ntag, " notify"}, {31'h0, notify}, {31'h0, exp_n});
    if (exp_n) begin
      chk({ntag, " dest"}, {16'h0, ndest}, {16'h0, wd[31:16]});
      chk({ntag, " vec"}, {24'h0, nvec}, {24'h0, wd[7:0]});
    end
    chk({tag, " rd_valid R11"}, {31'h0, rd_valid}, {31'h0, rd});
    if (rd) chk({tag, " rd_data"}, rd_data, exp_rd);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_mask = '0; m_cause = '0;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {31'h0, irq}, 32'h0);
    chk("R1 notify in reset", {31'h0, notify}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog R1 actual=%h expected=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    evt_valid = 0; evt_data = 0; local_id = 16'h00A5; shm_mapped = 1'b0;
    peer_max = 3'd5;
    for (int i = 0; i < NP; i++) peer_cnt[i*CW +: CW] = CW'(i);
    void'($urandom(32'h00C0FFEE));
    do_reset();

    // R1: outputs and registers after reset
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 rd_valid", {31'h0, rd_valid}, 32'h0);
    op(0, 1, 12'h000, 0, 0, 0, "R1 mask");
    op(0, 1, 12'h004, 0, 0, 0, "R1 cause");

    // R3 mask full replace and readback
    op(1, 0, 12'h000, 32'hDEAD_BEEF, 0, 0, "R3 wr");
    op(0, 1, 12'h000, 0, 0, 0, "R3 rd");
    // R4 event load, irq via enabled bit
    op(0, 0, 12'h040, 0, 1, 8'h0E, "R4 evt");
    // R5 read-clear
    op(0, 1, 12'h004, 0, 0, 0, "R5 rd");
    op(0, 1, 12'h004, 0, 0, 0, "R5 cleared");
    // R4 write vs event same cycle
    op(1, 0, 12'h004, 32'h8000_0001, 1, 8'hFF, "R4 collide");
    op(0, 1, 12'h004, 0, 0, 0, "R4 collide rd");
    // R5 read with event same cycle: event survives
    op(0, 0, 12'h000, 0, 1, 8'h03, "R5 pre");
    op(0, 1, 12'h004, 0, 1, 8'h40, "R5 evt+rd");
    op(0, 1, 12'h004, 0, 0, 0, "R5 evt kept");
    // R2 masked cause gives no irq
    op(1, 0, 12'h000, 32'h0000_0001, 0, 0, "R2 mask");
    op(0, 0, 12'h000, 0, 1, 8'h02, "R2 masked");
    op(0, 0, 12'h000, 0, 1, 8'h01, "R2 unmasked");
    // R6 position
    op(0, 1, 12'h008, 0, 0, 0, "R6 unmapped");
    shm_mapped = 1'b1;
    op(0, 1, 12'h008, 0, 0, 0, "R6 mapped");
    // R10 aliasing and unmapped words
    op(1, 0, 12'hF03, 32'h1234_5678, 0, 0, "R10 alias wr mask");
    op(0, 1, 12'h502, 0, 0, 0, "R10 alias rd mask");
    op(1, 0, 12'h010, 32'hFFFF_FFFF, 0, 0, "R10 wr unmapped");
    op(1, 0, 12'h008, 32'hFFFF_FFFF, 0, 0, "R10 wr pos");
    op(0, 1, 12'h000, 0, 0, 0, "R10 mask kept");
    op(0, 1, 12'h008, 0, 0, 0, "R10 pos kept");
    op(0, 1, 12'h00C, 0, 0, 0, "R10 rd bell");
    op(0, 1, 12'h0FC, 0, 0, 0, "R10 rd top");
    // R7/R8/R9 doorbell limits
    op(1, 0, 12'h00C, {16'd5, 8'h00, 8'd4}, 0, 0, "R7 max peer last vec");
    op(1, 0, 12'h00C, {16'd5, 8'h00, 8'd5}, 0, 0, "R9 vec eq count");
    op(1, 0, 12'h00C, {16'd6, 8'h00, 8'd0}, 0, 0, "R8 above max");
    op(1, 0, 12'h00C, {16'h8005, 8'h00, 8'd0}, 0, 0, "R8 high dest");
    op(1, 0, 12'h00C, {16'd0, 8'h00, 8'd0}, 0, 0, "R9 zero count");
    op(1, 0, 12'h00C, {16'd2, 8'hFF, 8'd1}, 0, 0, "R7 mid bits");
    op(0, 0, 12'h000, 0, 0, 0, "R7 single pulse");
    op(1, 0, 12'h00C, {16'd3, 8'h00, 8'd2}, 0, 0, "R7 b2b a");
    op(1, 0, 12'h00C, {16'd4, 8'h00, 8'd3}, 0, 0, "R7 b2b b");

    // random traffic
    for (int n = 0; n < 600; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      int k = int'($urandom % 8);
      int wsel = int'($urandom % 6);
      a = {4'($urandom), (wsel == 5) ? 6'(4 + $urandom % 60) : 6'(wsel % 4), 2'($urandom)};
      d = $urandom;
      if ((wsel % 4) == 3) d = {16'($urandom % 9), d[15:8], 8'($urandom % 8)};
      if (k < 4) op(1, 0, a, d, ($urandom % 4) == 0, 8'($urandom), "RND wr R3/R4/R10");
      else if (k < 7) op(0, 1, a, 0, ($urandom % 4) == 0, 8'($urandom), "RND rd R5/R6/R11");
      else op(0, 0, a, 0, 1'b1, 8'($urandom), "RND evt R4");
      if (n % 200 == 199) peer_max = 3'($urandom % 8);
    end

    // R1: reset mid-run clears state
    op(1, 0, 12'h000, 32'hFFFF_FFFF, 0, 0, "R1 pre mask");
    op(0, 0, 12'h000, 0, 1, 8'hFF, "R1 pre evt");
    do_reset();
    op(0, 1, 12'h000, 0, 0, 0, "R1 mask after");
    op(0, 1, 12'h004, 0, 0, 0, "R1 cause after");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule